// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Capture Unit

This block timestamps transitions of one external input. A 32-bit timebase counts the functional clock while its run bit is set. Each qualified transition of the input copies the current count into one of four capture slots. The slots fill in a fixed rotation, and each slot has its own edge polarity. The unit can rotate through the slots without end, or it can stop after a chosen slot and wait until software rearms it.

Each slot load sets a sticky event flag, and so does a wrap of the timebase. Any flag whose enable bit is set also raises one sticky interrupt line, which stays high until software clears it. Software reaches every register over a simple single-cycle 32-bit write port with a combinational read port. Reads of unmapped offsets return zero.

Top module: `tsc_capture_unit`

## Requirements
- R1: While control bit 20 (run) is 1, the timebase at offset 0x00 increases by one on every clock. A bus write to 0x00 loads the written value and takes priority over counting.
- R2: While run is 0, the timebase holds its value and no capture slot loads, whatever the input does.
- R3: Capture slot i (i = 0..3) sits at offset 0x08 + 4*i. A bus write stores the value there, and a read returns it.
- R4: The input passes through a two-flop synchronizer. A level change that is set up before clock edge E0 is detected after edge E0+1. The slot then loads at E0+2 with the timebase value held between E0+1 and E0+2, which is the count read before E0 plus 2. Control bit 2*i picks the edge for slot i: 0 means rising and 1 means falling.
- R5: Slots load only while control bit 8 (load enable) is 1.
- R6: Loads go to slots 0, 1, 2 and 3 in that order. In continuous mode (control bit 16 = 0) the order wraps from slot 3 back to slot 0. An edge that does not match the polarity of the current slot loads nothing and does not advance the slot.
- R7: In one-shot mode (control bit 16 = 1), loading stops after the slot named by control bits 18:17 has loaded. A control write with bit 19 set rearms the unit and restarts the order at slot 0. Bit 19 always reads back as 0.
- R8: In the register at 0x2C, read-only bits 17..20 are the flags for slots 0..3 and bit 21 is the overflow flag. Each flag sets when its slot loads, or, for overflow, when the timebase goes from 0xFFFFFFFF to 0.
- R9: A write to 0x30 with bit k+1 set clears flag k (k = 4 is overflow), and bit 0 set clears the global flag. Zero bits have no effect. A flag being set in the same cycle wins over a clear.
- R10: Bits 1..5 of 0x2C enable events 0..4. Bit 0 of 0x2C and the output irq_out show the global flag. The global flag sets when an enabled event occurs and stays set until it is cleared. Disabled events never set it.
- R11: After reset, the timebase, all slots, the control register, the enables and all flags read as zero, and irq_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_in | input | 1 | Asynchronous input to timestamp |
| irq_out | output | 1 | Sticky global interrupt flag |

## Verification
The capture path is driven with alternating transitions under a directed mix of polarities, and then with a seeded random polarity set and random gaps. A reference model predicts which slot each edge lands in. This separates an error in edge qualification from an error in slot rotation or in the two-cycle synchronizer latency. One-shot runs with an early stop slot show whether the freeze and the rearm restart at slot 0. Runs with the timebase frozen and with load enable off show that edges are ignored in each case. Two forced wraps, one with the overflow enable off and one with it on, tell apart a flag set without an interrupt from the sticky interrupt and its separate clear bits.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_SLOTS = 4;
    localparam int NUM_EVT   = NUM_SLOTS + 1;

    localparam logic [ADDR_W-1:0] OFS_TIMEBASE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SLOT0    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_ENFLAG   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_CLEAR    = 8'h30;

    localparam int CTL_LOAD_BIT  = 8;
    localparam int CTL_ONCE_BIT  = 16;
    localparam int CTL_STOP_LSB  = 17;
    localparam int CTL_REARM_BIT = 19;
    localparam int CTL_RUN_BIT   = 20;
    localparam int EN_LSB        = 1;
    localparam int FLAG_LSB      = 17;

    localparam logic [BUS_W-1:0] CTL_KEEP_MASK = 32'h0017_01FF;

    typedef struct packed {
        logic                 run;
        logic                 once;
        logic                 load_en;
        logic [1:0]           stop;
        logic [NUM_SLOTS-1:0] fall_sel;
    } ctrl_view_t;

    function automatic ctrl_view_t decode_ctrl(input logic [BUS_W-1:0] r);
        ctrl_view_t v;
        v.run     = r[CTL_RUN_BIT];
        v.once    = r[CTL_ONCE_BIT];
        v.load_en = r[CTL_LOAD_BIT];
        v.stop    = r[CTL_STOP_LSB +: 2];
        for (int i = 0; i < NUM_SLOTS; i++) v.fall_sel[i] = r[2*i];
        return v;
    endfunction

    function automatic logic [ADDR_W-1:0] slot_offset(input int idx);
        return OFS_SLOT0 + ADDR_W'(4 * idx);
    endfunction

endpackage

// File: rtl/tcu_edge_sync.sv
module tcu_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/tcu_timebase.sv
module tcu_timebase #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic         wrap
);
    always_ff @(posedge clk) begin
        if (rst)        count <= '0;
        else if (wr_en) count <= wr_data;
        else if (run)   count <= count + 1'b1;
    end

    assign wrap = run && !wr_en && (count == {W{1'b1}});
endmodule

// File: rtl/tcu_slot_seq.sv
module tcu_slot_seq #(
    parameter int N  = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          fall,
    input  logic [N-1:0]  fall_sel,
    input  logic          run,
    input  logic          load_en,
    input  logic          once,
    input  logic [PW-1:0] stop,
    input  logic          rearm,
    output logic [N-1:0]  load_vec
);
    logic [PW-1:0] ptr;
    logic          frozen;
    logic          hit;

    assign hit = (fall_sel[ptr] ? fall : rise) && run && load_en && !frozen;

    always_comb begin
        load_vec = '0;
        if (hit) load_vec[ptr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            ptr    <= '0;
            frozen <= 1'b0;
        end else if (hit) begin
            if (once && ptr == stop) frozen <= 1'b1;
            ptr <= (ptr == PW'(N-1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tsc_capture_unit.sv
module tsc_capture_unit
    import tcu_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              evt_in,
    output logic              irq_out
);
    logic [BUS_W-1:0]     ctrl_q;
    ctrl_view_t           cv;
    logic [CNT_W-1:0]     tb_count;
    logic                 tb_wrap;
    logic                 wr_tb, wr_ctrl, wr_enf, wr_clr, glob_clr, rearm;
    logic [NUM_SLOTS-1:0] wr_slot;
    logic                 e_rise, e_fall;
    logic [NUM_SLOTS-1:0] load_vec;
    logic [CNT_W-1:0]     slot_q [NUM_SLOTS];
    logic [NUM_EVT-1:0]   evt_pulse, flags_q, en_q, clr_mask;
    logic                 gflag_q;

    assign cv       = decode_ctrl(ctrl_q);
    assign wr_tb    = bus_wr && bus_addr == OFS_TIMEBASE;
    assign wr_ctrl  = bus_wr && bus_addr == OFS_CTRL;
    assign wr_enf   = bus_wr && bus_addr == OFS_ENFLAG;
    assign wr_clr   = bus_wr && bus_addr == OFS_CLEAR;
    assign glob_clr = wr_clr && bus_wdata[0];
    assign rearm    = wr_ctrl && bus_wdata[CTL_REARM_BIT];
    assign clr_mask = wr_clr ? bus_wdata[EN_LSB +: NUM_EVT] : '0;

    tcu_timebase #(.W(CNT_W)) u_tb (
        .clk(clk), .rst(rst), .run(cv.run), .wr_en(wr_tb),
        .wr_data(bus_wdata[CNT_W-1:0]), .count(tb_count), .wrap(tb_wrap)
    );

    tcu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(evt_in), .rise(e_rise), .fall(e_fall)
    );

    tcu_slot_seq #(.N(NUM_SLOTS)) u_seq (
        .clk(clk), .rst(rst), .rise(e_rise), .fall(e_fall),
        .fall_sel(cv.fall_sel), .run(cv.run), .load_en(cv.load_en),
        .once(cv.once), .stop(cv.stop), .rearm(rearm), .load_vec(load_vec)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign wr_slot[g] = bus_wr && bus_addr == slot_offset(g);
        always_ff @(posedge clk) begin
            if (rst)             slot_q[g] <= '0;
            else if (wr_slot[g]) slot_q[g] <= bus_wdata[CNT_W-1:0];
            else if (load_vec[g]) slot_q[g] <= tb_count;
        end
    end

    assign evt_pulse = {tb_wrap, load_vec};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            en_q    <= '0;
            flags_q <= '0;
            gflag_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata & CTL_KEEP_MASK;
            if (wr_enf)  en_q   <= bus_wdata[EN_LSB +: NUM_EVT];
            flags_q <= (flags_q & ~clr_mask) | evt_pulse;
            if (|(evt_pulse & en_q)) gflag_q <= 1'b1;
            else if (glob_clr)       gflag_q <= 1'b0;
        end
    end

    assign irq_out = gflag_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_TIMEBASE) bus_rdata = BUS_W'(tb_count);
        if (bus_addr == OFS_CTRL)     bus_rdata = ctrl_q;
        if (bus_addr == OFS_ENFLAG) begin
            bus_rdata[0]                  = gflag_q;
            bus_rdata[EN_LSB +: NUM_EVT]  = en_q;
            bus_rdata[FLAG_LSB +: NUM_EVT] = flags_q;
        end
        for (int i = 0; i < NUM_SLOTS; i++)
            if (bus_addr == slot_offset(i)) bus_rdata = BUS_W'(slot_q[i]);
    end
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
    parameter int CNT_W = 32,
    parameter int N     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             tb_wr,
    input logic [CNT_W-1:0] count,
    input logic [N-1:0]     loads,
    input logic             irq,
    input logic             gclr,
    input logic             ovf_flag
);
    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        (run && !tb_wr) |=> count == $past(count) + 1'b1);

    a_r2_frozen_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !tb_wr) |=> $stable(count));

    a_r2_no_load_frozen: assert property (@(posedge clk) disable iff (rst)
        !run |-> loads == '0);

    a_r6_single_slot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(loads));

    a_r8_wrap_flag: assert property (@(posedge clk) disable iff (rst)
        (run && !tb_wr && count == {CNT_W{1'b1}}) |=> ovf_flag);

    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !gclr) |=> irq);
endmodule

bind tsc_capture_unit tcu_checker #(.CNT_W(CNT_W), .N(tcu_pkg::NUM_SLOTS)) u_chk (
    .clk(clk), .rst(rst), .run(cv.run), .tb_wr(wr_tb), .count(tb_count),
    .loads(load_vec), .irq(irq_out), .gclr(glob_clr), .ovf_flag(flags_q[tcu_pkg::NUM_SLOTS])
);

// File: tb/tsc_capture_unit_test.sv
module tsc_capture_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_in = 1'b0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] exp_cap [4];
    int          ptr_m;
    logic        lvl;

    localparam logic [31:0] RUN  = 32'h0010_0000;
    localparam logic [31:0] LOAD = 32'h0000_0100;
    localparam logic [31:0] ONCE = 32'h0001_0000;
    localparam logic [31:0] RARM = 32'h0008_0000;

    always #4 clk = ~clk;

    tsc_capture_unit uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq_out(irq_out)
    );

    function automatic logic [31:0] stamp_of(input logic [31:0] c_before);
        return c_before + 32'd2;
    endfunction

    function automatic logic edge_hits(input logic fall_sel, input logic new_lvl);
        return fall_sel ? !new_lvl : new_lvl;
    endfunction

    function automatic logic [31:0] pol_bits(input logic [3:0] p);
        return {25'b0, p[3], 1'b0, p[2], 1'b0, p[1], 1'b0, p[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic toggle(input logic v, input int gap, output logic [31:0] c);
        @(negedge clk);
        bus_addr = 8'h00;
        #1 c = bus_rdata;
        evt_in = v;
        repeat (4 + gap) @(negedge clk);
    endtask

    task automatic model_edge(input logic [3:0] pol, input logic v, input logic [31:0] c);
        if (edge_hits(pol[ptr_m], v)) begin
            exp_cap[ptr_m] = stamp_of(c);
            ptr_m = (ptr_m + 1) % 4;
        end
    endtask

    task automatic check_caps(input string req);
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            rd(8'h08 + 8'(4*i), d);
            chk(req, d, exp_cap[i]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, a, c;
        logic [3:0]  pol;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset values
        rd(8'h00, d); chk("R11 timebase", d, 0);
        rd(8'h28, d); chk("R11 ctrl", d, 0);
        rd(8'h2C, d); chk("R11 enflag", d, 0);
        chk("R11 irq", 32'(irq_out), 0);
        for (int i = 0; i < 4; i++) begin
            rd(8'h08 + 8'(4*i), d); chk("R11 slot", d, 0);
            exp_cap[i] = 0;
        end

        // R2 frozen: load enabled, run off
        wr(8'h28, LOAD);
        rd(8'h00, a);
        toggle(1'b1, 0, c); toggle(1'b0, 0, c);
        rd(8'h00, d); chk("R2 timebase holds", d, a);
        check_caps("R2 no load when frozen");

        // R3 slot write/read
        for (int i = 0; i < 4; i++) begin
            exp_cap[i] = 32'hA5A5_0000 + 32'(i);
            wr(8'h08 + 8'(4*i), exp_cap[i]);
        end
        check_caps("R3 slot readback");

        // R1 counting and load
        wr(8'h00, 32'd100);
        wr(8'h28, RUN);
        rd(8'h00, a);
        repeat (4) @(negedge clk);
        rd(8'h00, d); chk("R1 step", d, a + 32'd5);

        // R5 load enable off: edges ignored
        toggle(1'b1, 0, c); toggle(1'b0, 0, c);
        check_caps("R5 no load when disabled");

        // R4 R6 directed polarity and continuous rotation
        pol = 4'b1010;
        wr(8'h28, RUN | LOAD | RARM | pol_bits(pol));
        rd(8'h28, d); chk("R7 rearm bit reads zero", d, RUN | LOAD | pol_bits(pol));
        ptr_m = 0; lvl = 1'b0;
        for (int k = 0; k < 5; k++) begin
            lvl = ~lvl;
            toggle(lvl, 0, c);
            model_edge(pol, lvl, c);
        end
        check_caps("R4 R6 directed capture");
        rd(8'h2C, d); chk("R8 slot flags", d[21:17], 5'b01111);

        // R6 random polarity, random gaps
        wr(8'h30, 32'h3F);
        pol = 4'($urandom);
        wr(8'h28, RUN | LOAD | RARM | pol_bits(pol));
        ptr_m = 0;
        for (int k = 0; k < 40; k++) begin
            lvl = ~lvl;
            toggle(lvl, int'($urandom % 3), c);
            model_edge(pol, lvl, c);
        end
        check_caps("R6 random rotation");

        // R7 one-shot stop at slot 1, then rearm
        wr(8'h30, 32'h3F);
        wr(8'h28, RUN | LOAD | ONCE | RARM | 32'h0002_0000);
        ptr_m = 0; pol = 4'b0000;
        for (int k = 0; k < 6; k++) begin
            lvl = ~lvl;
            toggle(lvl, 0, c);
            if (ptr_m < 2) model_edge(pol, lvl, c);
        end
        check_caps("R7 one-shot freeze");
        rd(8'h2C, d); chk("R7 flags after stop", d[21:17], 5'b00011);
        wr(8'h28, RUN | LOAD | ONCE | RARM | 32'h0002_0000);
        ptr_m = 0;
        lvl = ~lvl; toggle(lvl, 0, c); model_edge(pol, lvl, c);
        lvl = ~lvl; toggle(lvl, 0, c); model_edge(pol, lvl, c);
        check_caps("R7 rearm restarts at slot 0");

        // R8 R10 overflow with enable off
        wr(8'h30, 32'h3F);
        wr(8'h28, RUN);
        wr(8'h00, 32'hFFFF_FFFD);
        repeat (6) @(negedge clk);
        rd(8'h2C, d); chk("R8 overflow flag", d[21], 1);
        chk("R10 disabled event no irq", 32'(irq_out), 0);

        // R10 overflow enabled
        wr(8'h30, 32'h20);
        rd(8'h2C, d); chk("R9 overflow flag cleared", d[21], 0);
        wr(8'h2C, 32'h20);
        wr(8'h00, 32'hFFFF_FFFE);
        repeat (5) @(negedge clk);
        chk("R10 irq set", 32'(irq_out), 1);
        rd(8'h2C, d); chk("R10 enflag read", d & 32'h0020_003F, 32'h0020_0021);

        // R9 clears
        wr(8'h30, 32'h0);
        rd(8'h2C, d); chk("R9 zero write no effect", d & 32'h0020_0001, 32'h0020_0001);
        wr(8'h30, 32'h20);
        rd(8'h2C, d); chk("R9 clear ovf only", d[21], 0);
        chk("R10 irq sticky after flag clear", 32'(irq_out), 1);
        wr(8'h30, 32'h1);
        chk("R9 global clear", 32'(irq_out), 0);

        finish_run();
    end
endmodule